// File: doc/BRIEF.md
# Lockable Check Control Register File

This block is the software-facing register file that sits in front of a periodic integrity and consistency check engine. A simple single-cycle register bus reaches seven word-aligned registers: a status word, two one-way lock bits, a pulse-only trigger register, a check timeout and two period masks.

The status word is assembled from the error, idle, timeout and pending levels that the engine and its neighbours drive in. The trigger register never stores anything. An accepted write turns its low two bits into one-cycle pulses that start a one-off integrity or consistency check.

The first lock guards the trigger register. The second lock guards the timeout and both period masks. Software clears a lock by writing 1 to it, and only reset sets it again. The block also combines the error levels into an error interrupt level and a check-failed alert level.

Top module: `chk_csr_regfile`

## Requirements
- R1: The trigger lock (offset 0x04, bit 0) resets to 1. A bus write to 0x04 with wdata bit 0 = 1 clears it to 0 from the next cycle on. Writing 0 leaves it unchanged. Nothing except reset returns it to 1. Reading 0x04 returns the lock in bit 0 and zeros above.
- R2: While the trigger lock is 0, writes to the trigger register (0x08) produce no pulse on either trigger output.
- R3: An accepted write to 0x08 drives integ_trig_o high for exactly the one cycle after the write when wdata bit 0 is 1. It drives cnsty_trig_o the same way when wdata bit 1 is 1. Reading 0x08 always returns 0.
- R4: The config lock (0x0C, bit 0) has the same one-way write-1-to-clear behaviour as the trigger lock and resets to 1. While it is 0, writes to 0x10, 0x14 and 0x18 are ignored.
- R5: The timeout register (0x10, 32 bits) resets to 0. It can be written while the config lock is 1, and it reads back and drives timeout_o. The value 0 means the timeout is disabled.
- R6: The integrity period mask (0x14) and the consistency period mask (0x18) are 32 bits each and reset to 0. They can be written while the config lock is 1, and they read back and drive their outputs. The value 0 disables the matching periodic timer.
- R7: The status word at 0x00 is packed as follows: bits 6..0 carry part_err_i, bit 7 dai_err_i, bit 8 lci_err_i, bit 9 chk_timeout_i, bit 10 dai_idle_i, bit 11 chk_pending_i, and bits 31..12 read 0.
- R8: err_irq_o is the OR of part_err_i, dai_err_i, lci_err_i and chk_timeout_i.
- R9: chk_alert_o is high whenever chk_timeout_i is high or any bit of part_chk_fail_i is high.
- R10: Read data is registered. It appears on bus_rdata the cycle after bus_re and holds until the next read. Addresses outside the map read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| part_err_i | input | NUM_PART | Per-partition error levels |
| part_chk_fail_i | input | NUM_PART | Per-partition check-class error levels |
| dai_err_i | input | 1 | Direct-access error level |
| lci_err_i | input | 1 | Life-cycle interface error level |
| chk_timeout_i | input | 1 | Check timeout level from the engine |
| dai_idle_i | input | 1 | Direct-access idle level |
| chk_pending_i | input | 1 | Check pending level from the engine |
| trig_unlocked_o | output | 1 | Current trigger lock bit |
| cfg_unlocked_o | output | 1 | Current config lock bit |
| integ_trig_o | output | 1 | One-cycle integrity check trigger |
| cnsty_trig_o | output | 1 | One-cycle consistency check trigger |
| timeout_o | output | 32 | Check timeout value |
| integ_mask_o | output | 32 | Integrity period mask |
| cnsty_mask_o | output | 32 | Consistency period mask |
| err_irq_o | output | 1 | Error interrupt level |
| chk_alert_o | output | 1 | Check-failed alert level |

## Verification
The properties assume that the bus carries at most one write per cycle and that bus_addr and bus_wdata are valid whenever a strobe is high. The bench drives every strobe for a single cycle from the falling edge and never overlaps a read with a write, so both conditions always hold. The status and error inputs change only between bus accesses and are held steady through each read, which keeps the registered status sample well defined. Random writes to the lock addresses mostly carry bit 0 cleared, so both locks stay open for most of the random phase and the config and trigger paths get exercised before directed steps close them.

// File: rtl/chk_csr_regfile.sv
module chk_csr_regfile #(
  parameter int ADDR_W   = 8,
  parameter int NUM_PART = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_we,
  input  logic                bus_re,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PART-1:0] part_err_i,
  input  logic [NUM_PART-1:0] part_chk_fail_i,
  input  logic                dai_err_i,
  input  logic                lci_err_i,
  input  logic                chk_timeout_i,
  input  logic                dai_idle_i,
  input  logic                chk_pending_i,
  output logic                trig_unlocked_o,
  output logic                cfg_unlocked_o,
  output logic                integ_trig_o,
  output logic                cnsty_trig_o,
  output logic [31:0]         timeout_o,
  output logic [31:0]         integ_mask_o,
  output logic [31:0]         cnsty_mask_o,
  output logic                err_irq_o,
  output logic                chk_alert_o
);

  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_TLOCK = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CLOCK = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_TOUT  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_CMASK = ADDR_W'(8'h18);
  localparam int STAT_W = NUM_PART + 5;

  logic              trig_lock_q, cfg_lock_q;
  logic              integ_trig_q, cnsty_trig_q;
  logic [31:0]       tout_q, imask_q, cmask_q;
  logic [31:0]       rdata_q, rd_mux;
  logic [STAT_W-1:0] status;

  wire wr_tlock = bus_we && bus_addr == A_TLOCK;
  wire wr_trig  = bus_we && bus_addr == A_TRIG && trig_lock_q;
  wire wr_clock = bus_we && bus_addr == A_CLOCK;
  wire cfg_ok   = bus_we && cfg_lock_q;

  assign status = {chk_pending_i, dai_idle_i, chk_timeout_i, lci_err_i, dai_err_i, part_err_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_lock_q <= 1'b1;
      cfg_lock_q  <= 1'b1;
    end else begin
      if (wr_tlock && bus_wdata[0]) trig_lock_q <= 1'b0;
      if (wr_clock && bus_wdata[0]) cfg_lock_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_trig_q <= 1'b0;
      cnsty_trig_q <= 1'b0;
    end else begin
      integ_trig_q <= wr_trig && bus_wdata[0];
      cnsty_trig_q <= wr_trig && bus_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout_q  <= '0;
      imask_q <= '0;
      cmask_q <= '0;
    end else if (cfg_ok) begin
      if (bus_addr == A_TOUT)  tout_q  <= bus_wdata;
      if (bus_addr == A_IMASK) imask_q <= bus_wdata;
      if (bus_addr == A_CMASK) cmask_q <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_STAT:  rd_mux = 32'(status);
      A_TLOCK: rd_mux = {31'b0, trig_lock_q};
      A_CLOCK: rd_mux = {31'b0, cfg_lock_q};
      A_TOUT:  rd_mux = tout_q;
      A_IMASK: rd_mux = imask_q;
      A_CMASK: rd_mux = cmask_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_mux;
  end

  assign bus_rdata       = rdata_q;
  assign trig_unlocked_o = trig_lock_q;
  assign cfg_unlocked_o  = cfg_lock_q;
  assign integ_trig_o    = integ_trig_q;
  assign cnsty_trig_o    = cnsty_trig_q;
  assign timeout_o       = tout_q;
  assign integ_mask_o    = imask_q;
  assign cnsty_mask_o    = cmask_q;
  assign err_irq_o       = |{part_err_i, dai_err_i, lci_err_i, chk_timeout_i};
  assign chk_alert_o     = chk_timeout_i | (|part_chk_fail_i);

endmodule

// File: rtl/chk_csr_regfile_sva.sv
module chk_csr_regfile_sva #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic              trig_unlocked_o,
  input logic              cfg_unlocked_o,
  input logic              integ_trig_o,
  input logic              cnsty_trig_o,
  input logic [31:0]       timeout_o,
  input logic [31:0]       integ_mask_o,
  input logic [31:0]       cnsty_mask_o,
  input logic              chk_timeout_i,
  input logic              err_irq_o,
  input logic              chk_alert_o
);

  wire unmapped = bus_addr > ADDR_W'(8'h18) || bus_addr[1:0] != 2'b00;

  a_r1_trig_lock_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_unlocked_o |=> !trig_unlocked_o);

  a_r4_cfg_lock_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlocked_o |=> !cfg_unlocked_o);

  a_r2_locked_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_unlocked_o |=> !integ_trig_o && !cnsty_trig_o);

  a_r3_integ_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    integ_trig_o |-> $past(bus_we && bus_addr == ADDR_W'(8'h08) && trig_unlocked_o && bus_wdata[0]));

  a_r3_cnsty_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cnsty_trig_o |-> $past(bus_we && bus_addr == ADDR_W'(8'h08) && trig_unlocked_o && bus_wdata[1]));

  a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlocked_o |=> $stable(timeout_o) && $stable(integ_mask_o) && $stable(cnsty_mask_o));

  a_r8_timeout_irq: assert property (@(posedge clk) disable iff (!rst_n)
    chk_timeout_i |-> err_irq_o);

  a_r9_timeout_alert: assert property (@(posedge clk) disable iff (!rst_n)
    chk_timeout_i |-> chk_alert_o);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && unmapped |=> bus_rdata == 32'h0);

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

endmodule

bind chk_csr_regfile chk_csr_regfile_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .trig_unlocked_o(trig_unlocked_o), .cfg_unlocked_o(cfg_unlocked_o),
  .integ_trig_o(integ_trig_o), .cnsty_trig_o(cnsty_trig_o),
  .timeout_o(timeout_o), .integ_mask_o(integ_mask_o), .cnsty_mask_o(cnsty_mask_o),
  .chk_timeout_i(chk_timeout_i), .err_irq_o(err_irq_o), .chk_alert_o(chk_alert_o)
);

// File: tb/chk_csr_regfile_tb.sv
module chk_csr_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [6:0]  part_err = '0, part_fail = '0;
  logic        dai_err = 0, lci_err = 0, tmo = 0, idle = 0, pend = 0;
  logic        t_unl, c_unl, itrig, ctrig, irq, alert;
  logic [31:0] tout, imask, cmask;

  int n_checks = 0, n_fail = 0;
  logic        m_tl = 1, m_cl = 1;
  logic [31:0] m_to = 0, m_im = 0, m_cm = 0;

  chk_csr_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .part_err_i(part_err), .part_chk_fail_i(part_fail), .dai_err_i(dai_err),
    .lci_err_i(lci_err), .chk_timeout_i(tmo), .dai_idle_i(idle), .chk_pending_i(pend),
    .trig_unlocked_o(t_unl), .cfg_unlocked_o(c_unl), .integ_trig_o(itrig),
    .cnsty_trig_o(ctrig), .timeout_o(tout), .integ_mask_o(imask), .cnsty_mask_o(cmask),
    .err_irq_o(irq), .chk_alert_o(alert)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return {20'b0, pend, idle, tmo, lci_err, dai_err, part_err};
      8'h04: return {31'b0, m_tl};
      8'h0C: return {31'b0, m_cl};
      8'h10: return m_to;
      8'h14: return m_im;
      8'h18: return m_cm;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_outputs(input string tag);
    check({tag, " R1 lock"}, {31'b0, t_unl}, {31'b0, m_tl});
    check({tag, " R4 lock"}, {31'b0, c_unl}, {31'b0, m_cl});
    check({tag, " R5 timeout"}, tout, m_to);
    check({tag, " R6 imask"}, imask, m_im);
    check({tag, " R6 cmask"}, cmask, m_cm);
  endtask

  task automatic check_levels();
    #1;
    check("R8 irq", {31'b0, irq}, {31'b0, |{part_err, dai_err, lci_err, tmo}});
    check("R9 alert", {31'b0, alert}, {31'b0, tmo | (|part_fail)});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [1:0] ep;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    ep = (a == 8'h08 && m_tl) ? d[1:0] : 2'b00;
    if (a == 8'h04 && d[0]) m_tl = 1'b0;
    if (a == 8'h0C && d[0]) m_cl = 1'b0;
    if (m_cl && a == 8'h10) m_to = d;
    if (m_cl && a == 8'h14) m_im = d;
    if (m_cl && a == 8'h18) m_cm = d;
    @(negedge clk);
    bus_we = 1'b0;
    check(a == 8'h08 ? (m_tl ? "R3 pulse" : "R2 locked pulse") : "R3 no pulse",
          {30'b0, ctrig, itrig}, {30'b0, ep});
    check_outputs("after write");
    @(negedge clk);
    check("R3 pulse one cycle", {30'b0, ctrig, itrig}, 32'h0);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(tag, bus_rdata, exp_read(a));
    bus_addr = 8'hF0;
    @(negedge clk);
    check("R10 rdata held", bus_rdata, exp_read(a));
  endtask

  task automatic rand_inputs();
    part_err = 7'($urandom); part_fail = 7'($urandom);
    if ($urandom % 3 == 0) part_err = '0;
    if ($urandom % 3 == 0) part_fail = '0;
    dai_err = 1'($urandom); lci_err = 1'($urandom); tmo = ($urandom % 4 == 0);
    idle = 1'($urandom); pend = 1'($urandom);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] amap [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h22, 8'hFC};
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("reset");
    check("R3 reset trig", {30'b0, ctrig, itrig}, 32'h0);
    rd(8'h04, "R1 reset lock read");
    rd(8'h0C, "R4 reset lock read");
    rd(8'h10, "R5 reset timeout");
    rd(8'h14, "R6 reset imask");
    rd(8'h00, "R7 status zero");
    check_levels();

    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h04, "R1 write 0 no effect");
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h14, 32'h0003_FFFF);
    wr(8'h18, 32'h03FF_FFFF);
    rd(8'h10, "R5 readback");
    rd(8'h14, "R6 readback integ");
    rd(8'h18, "R6 readback cnsty");
    wr(8'h08, 32'h1);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h3);
    rd(8'h08, "R3 trig reads zero");
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, "R10 unmapped read");

    part_err = 7'h40; dai_err = 1; lci_err = 0; tmo = 0; idle = 1; pend = 1; part_fail = 0;
    rd(8'h00, "R7 status pattern");
    check_levels();
    part_err = 0; dai_err = 0; tmo = 1;
    check_levels();
    tmo = 0; part_fail = 7'h04;
    check_levels();

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      rand_inputs();
      check_levels();
      a = amap[$urandom % 10];
      d = $urandom;
      if ((a == 8'h04 || a == 8'h0C) && ($urandom % 60 != 0)) d[0] = 1'b0;
      if ($urandom % 2 == 0) wr(a, d);
      else rd(a, "R10 random read R7");
    end

    wr(8'h04, 32'h1);
    wr(8'h04, 32'h0);
    rd(8'h04, "R1 stays cleared");
    wr(8'h08, 32'h3);
    wr(8'h08, 32'h1);
    wr(8'h0C, 32'h1);
    wr(8'h10, 32'h1111_1111);
    wr(8'h14, 32'h2222_2222);
    wr(8'h18, 32'h3333_3333);
    rd(8'h10, "R4 timeout frozen");
    rd(8'h18, "R4 cmask frozen");
    rd(8'h0C, "R4 stays cleared");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule